// File: doc/BRIEF.md
# Presettable Binary Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter with a parallel preset bus. Its terminal-count flag is active low and is decoded from the registered count. An active-low load enable copies the preset value into the counter on a rising clock edge. An active-low count enable advances it by one per edge. A reload gate input makes the counter copy the preset value back in on the edge that sees terminal count. With a preset value P, the counter then divides the clock by 2^WIDTH − P.

Each edge, the controls select one of four operations, decoded into an enumerated type:
- `OP_LOAD`: load enable low.
- `OP_HOLD`: load enable high and count enable high.
- `OP_WRAPLOAD`: counting enabled, reload gate high and terminal count asserted.
- `OP_STEP`: every other case.

Each operation moves the count register to its next state:
- preset value for `OP_LOAD` and `OP_WRAPLOAD`;
- the same value for `OP_HOLD`;
- value plus one for `OP_STEP`.

An asynchronous master reset clears the counter at once. Its release is synchronised to the clock through `RST_SYNC_STAGES` flops. A system that does not use the reload gate should tie it low, which disables reload.

Top module: `preset_counter`

## Requirements
- R1: When `load_n` is 0 at a rising edge, `count` takes the value of `preset` at that edge, whatever `cnt_en_n` and `wrap_reload` are.
- R2: When `load_n`=1, `cnt_en_n`=0 and `wrap_reload`=0, each rising edge sets `count` to its previous value plus one modulo 2^WIDTH, so all ones is followed by zero.
- R3: When `load_n`=1, `cnt_en_n`=0 and `wrap_reload`=1, an edge that sees `term_n`=0 loads `preset`, and other edges increment. After loading P, `count` returns to P after exactly 2^WIDTH − P edges.
- R4: When `load_n`=1 and `cnt_en_n`=1, `count` keeps its value. This holds even when `wrap_reload`=1 and `term_n`=0.
- R5: `term_n` is 0 exactly when every bit of `count` is 1, independent of the enables and of the reload gate.
- R6: While `rst_async` is 1, `count` is zero and `term_n` is 1 without any clock edge, overriding all other inputs.
- R7: After `rst_async` falls, the first `RST_SYNC_STAGES` rising edges leave `count` at zero. The next edge is the first to act on the controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_async | input | 1 | Asynchronous master reset, active high |
| load_n | input | 1 | Parallel load enable, active low, highest priority |
| cnt_en_n | input | 1 | Count enable, active low |
| wrap_reload | input | 1 | Reload gate: 1 reloads the preset at terminal count |
| preset | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Registered count |
| term_n | output | 1 | Terminal count, active low, low when count is all ones |

## Verification
The bench builds the counter with WIDTH=4 and RST_SYNC_STAGES=2. The 16-value space makes an exhaustive sweep affordable: every starting count, every preset value and all eight combinations of the three control inputs, each checked against an arithmetic next-count model. The same width lets the divide-by-N period be measured for every preset from 0 to 15, including the period-1 case at all ones. The two-stage release makes the ignored edges after reset a small, countable window.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'd0,
        OP_HOLD     = 2'd1,
        OP_STEP     = 2'd2,
        OP_WRAPLOAD = 2'd3
    } op_e;

endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_async,
    output logic rst_q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge rst_async) begin
                if (rst_async) chain <= '1;
                else           chain <= '0;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge rst_async) begin
                if (rst_async) chain <= '1;
                else           chain <= {chain[STAGES-2:0], 1'b0};
            end
        end
    endgenerate

    assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/pc_op_decode.sv
module pc_op_decode
    import pc_pkg::*;
(
    input  logic load_n,
    input  logic cnt_en_n,
    input  logic wrap_reload,
    input  logic at_term,
    output op_e  op
);
    always_comb begin
        if (!load_n)                       op = OP_LOAD;
        else if (cnt_en_n)                 op = OP_HOLD;
        else if (wrap_reload && at_term)   op = OP_WRAPLOAD;
        else                               op = OP_STEP;
    end
endmodule

// File: rtl/pc_count_reg.sv
module pc_count_reg
    import pc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_q,
    input  op_e              op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_LOAD, OP_WRAPLOAD: nxt = preset;
            OP_HOLD:              nxt = count;
            OP_STEP:              nxt = count + WIDTH'(1);
            default:              nxt = count;
        endcase
    end

    always_ff @(posedge clk or posedge rst_q) begin
        if (rst_q) count <= '0;
        else       count <= nxt;
    end
endmodule

// File: rtl/pc_tc_decode.sv
module pc_tc_decode #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count,
    output logic             at_term,
    output logic             term_n
);
    assign at_term = &count;
    assign term_n  = ~at_term;
endmodule

// File: rtl/preset_counter.sv
module preset_counter
    import pc_pkg::*;
#(
    parameter int WIDTH           = 8,
    parameter int RST_SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_async,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             wrap_reload,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             term_n
);
    logic rst_q;
    logic at_term;
    op_e  op;

    pc_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
        .clk       (clk),
        .rst_async (rst_async),
        .rst_q     (rst_q)
    );

    pc_op_decode u_dec (
        .load_n      (load_n),
        .cnt_en_n    (cnt_en_n),
        .wrap_reload (wrap_reload),
        .at_term     (at_term),
        .op          (op)
    );

    pc_count_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst_q  (rst_q),
        .op     (op),
        .preset (preset),
        .count  (count)
    );

    pc_tc_decode #(.WIDTH(WIDTH)) u_tc (
        .count   (count),
        .at_term (at_term),
        .term_n  (term_n)
    );
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_async,
    input logic             rst_q,
    input logic             load_n,
    input logic             cnt_en_n,
    input logic             wrap_reload,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             term_n
);
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst_async)
        (!rst_q && !load_n) |=> (count == $past(preset)));  // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst_async)
        (!rst_q && load_n && !cnt_en_n && !(wrap_reload && !term_n))
        |=> (count == WIDTH'($past(count) + WIDTH'(1))));  // R2

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst_async)
        (!rst_q && load_n && !cnt_en_n && wrap_reload && !term_n)
        |=> (count == $past(preset)));  // R3

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst_async)
        (!rst_q && load_n && cnt_en_n) |=> $stable(count));  // R4

    AST_TERM_ALL_ONES: assert property (@(posedge clk)
        (!term_n) == ($countones(count) == WIDTH));  // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst_async |-> (count == '0 && term_n));  // R6

    AST_RELEASE_ZERO: assert property (@(posedge clk)
        rst_q |-> (count == '0));  // R7
endmodule

bind preset_counter pc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_async   (rst_async),
    .rst_q       (rst_q),
    .load_n      (load_n),
    .cnt_en_n    (cnt_en_n),
    .wrap_reload (wrap_reload),
    .preset      (preset),
    .count       (count),
    .term_n      (term_n)
);

// File: tb/sim_preset_counter.sv
`timescale 1ns/1ps
module sim_preset_counter;
    localparam int W   = 4;
    localparam int STG = 2;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_async = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         wrap_reload = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         term_n;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    int model   = 0;

    always #2.5 clk = ~clk;

    preset_counter #(.WIDTH(W), .RST_SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_async(rst_async), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .wrap_reload(wrap_reload), .preset(preset), .count(count), .term_n(term_n)
    );

    task automatic check(input string req, input int exp_cnt);
        int exp_tc;
        exp_tc = (exp_cnt == TOP) ? 0 : 1;
        vectors++;
        if (int'(count) != exp_cnt || int'(term_n) != exp_tc) begin
            misses++;
            $display("FAIL %s: count=%0d term_n=%0d expected count=%0d term_n=%0d",
                     req, count, term_n, exp_cnt, exp_tc);
        end
    endtask

    function automatic int next_of(int cur, bit ld, bit en, bit wr, int pre);
        if (!ld)                    return pre;
        if (en)                     return cur;
        if (wr && cur == TOP)       return pre;
        return (cur + 1) % (TOP + 1);
    endfunction

    task automatic edge_apply(input bit ld, input bit en, input bit wr, input int pre,
                              input string req);
        @(negedge clk);
        load_n = ld; cnt_en_n = en; wrap_reload = wr; preset = W'(pre);
        model = next_of(model, ld, en, wr, pre);
        @(posedge clk); #1;
        check(req, model);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R6: reset state with no clock dependence
        #1; check("R6", 0);
        repeat (3) @(posedge clk);
        #1; check("R6", 0);

        // R7: release, first STG edges ignored even with load requested
        @(negedge clk);
        rst_async = 1'b0; load_n = 1'b0; preset = 4'd5;
        for (int i = 0; i < STG; i++) begin
            @(posedge clk); #1; check("R7", 0);
        end
        @(posedge clk); #1; check("R7", 5);
        model = 5;

        // R1..R5: exhaustive start x preset x control sweep
        for (int st = 0; st <= TOP; st++)
            for (int p = 0; p <= TOP; p++)
                for (int c = 0; c < 8; c++) begin
                    edge_apply(1'b0, 1'b1, 1'b0, st, "R1");
                    edge_apply(c[2], c[1], c[0], p,
                        !c[2] ? "R1" : c[1] ? "R4" : (c[0] && st == TOP) ? "R3" : "R2/R5");
                end

        // R4: hold at all ones with reload gate high stays put, term_n low
        edge_apply(1'b0, 1'b0, 1'b1, TOP, "R1");
        for (int i = 0; i < 4; i++) edge_apply(1'b1, 1'b1, 1'b1, 3, "R4");

        // R2: free-run wrap through all ones to zero
        edge_apply(1'b0, 1'b0, 1'b0, TOP - 1, "R1");
        for (int i = 0; i < 20; i++) edge_apply(1'b1, 1'b0, 1'b0, 9, "R2");

        // R3: divide-by-N period for every preset
        for (int p = 0; p <= TOP; p++) begin
            int n;
            edge_apply(1'b0, 1'b0, 1'b1, p, "R3");
            n = 0;
            do begin
                edge_apply(1'b1, 1'b0, 1'b1, p, "R3");
                n++;
            end while (int'(count) != p && n < 40);
            vectors++;
            if (n != (TOP + 1 - p)) begin
                misses++;
                $display("FAIL R3: period=%0d expected=%0d", n, TOP + 1 - p);
            end
        end

        // R6: asynchronous reset mid-cycle clears at once
        edge_apply(1'b0, 1'b0, 1'b0, 11, "R1");
        @(negedge clk); #1;
        rst_async = 1'b1; #0.5;
        check("R6", 0);
        #0.5; rst_async = 1'b0;
        model = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule